// File: doc/BRIEF.md
# Router Power Domain Sleep Controller

This block runs the sleep and wake control for the fine-grained power domains of a five-port on-chip router. Each virtual-channel input buffer, each crossbar output multiplexer, each virtual-channel output multiplexer and each output latch is a separate domain. With five ports and four virtual channels that makes 35 domains. The router datapath asks for a domain with a wake request when a flit is about to need it. It reports the domain idle once the packet has gone.

Each domain has its own three-state machine: asleep, waking and powered. While a domain is waking, the power switch is already closed. A cycle counter sets the wakeup time. Until the counter completes, the isolation enable stays high, which clamps the domain outputs, and a stall is raised toward the logic that would use the domain.

A gating-level parameter picks which classes of domain may sleep at all. An always-on mask pins chosen input buffers powered. By default these are virtual channels 0 and 2 of the local port.

Top module: `pgc_router_sleep_ctrl`

## Requirements
- R1: After reset, every domain that can be gated has `pwr_on`=0 and `iso_en`=1. Every forced-on domain has `pwr_on`=1 and `iso_en`=0.
- R2: A wake request to a sleeping domain is sampled at a clock edge. From that edge, `pwr_on` is 1 and `iso_en` stays 1. `iso_en` drops to 0 exactly WAKE_LAT edges after the sampling edge, counting the sampling edge as the first. WAKE_LAT may be 2, 3 or 4.
- R3: Further wake requests while a domain is waking do not restart the count. The release time stays that of the first request.
- R4: A powered domain whose idle input is 1 and whose wake input is 0 at an edge goes to sleep on that edge: `pwr_on`=0 and `iso_en`=1.
- R5: If idle and wake are both 1 at an edge on a powered domain, the domain stays powered with `iso_en`=0.
- R6: Idle is ignored while a domain is waking. `pwr_on` stays 1 and the count completes.
- R7: Input buffers whose bit is set in AON_MASK never sleep. Such a buffer has `pwr_on`=1 and `iso_en`=0 whatever its idle input. Mask bit b is buffer index b. The default mask is 20'h50000, which selects port 4, VC0 and VC2.
- R8: PG_LEVEL=1 gates only input buffers. PG_LEVEL=2 also gates both multiplexer classes. PG_LEVEL=3 also gates the output latches. Domains outside the gated set behave as forced on.
- R9: `in_stall[b]` equals `iso_en[b]`. `out_stall[p]` is 1 while any of the crossbar mux, VC mux or output latch domains of output port p has `iso_en`=1.
- R10: Domain index layout: the buffer of port p, VC v is index p*NVC+v. Crossbar mux p is NPORT*NVC+p. VC mux p is NPORT*NVC+NPORT+p. Output latch p is NPORT*NVC+2*NPORT+p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dom_wake | input | 35 | Per-domain wake request |
| dom_idle | input | 35 | Per-domain idle (buffer empty, packet gone) |
| pwr_on | output | 35 | Power switch enable per domain |
| iso_en | output | 35 | Output clamp enable per domain (1 = not ready) |
| in_stall | output | 20 | Per input buffer stall toward upstream |
| out_stall | output | 5 | Per output port stall for the crossbar path |

## Verification
A wake request put on the inputs while cycle counter n is current is sampled at the next edge. From cycle n+1 the power enable is visible. The isolation release and the matching stall release become visible at cycle n+WAKE_LAT. A sleep caused by idle becomes visible at cycle n+1. The bench queues each expected value with its due cycle when it drives the stimulus. The monitor compares the value one time unit after that edge, so every check lands in the exact cycle the requirement names. A second instance with level 1 and a two-cycle wakeup covers the level selection and the shortest latency.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [1:0] {
        PD_OFF    = 2'd0,
        PD_WAKING = 2'd1,
        PD_ON     = 2'd2
    } pd_state_e;

    typedef enum logic [1:0] {
        DK_BUF   = 2'd0,
        DK_XBAR  = 2'd1,
        DK_VCMUX = 2'd2,
        DK_OLAT  = 2'd3
    } dom_kind_e;

    typedef struct packed {
        logic pwr_on;
        logic iso_en;
    } pd_ctrl_t;

    function automatic dom_kind_e kind_of(input int idx, input int nbuf, input int nport);
        if (idx < nbuf)                return DK_BUF;
        else if (idx < nbuf + nport)   return DK_XBAR;
        else if (idx < nbuf + 2*nport) return DK_VCMUX;
        else                           return DK_OLAT;
    endfunction

    function automatic bit kind_gated(input dom_kind_e k, input int level);
        case (k)
            DK_BUF:            return level >= 1;
            DK_XBAR, DK_VCMUX: return level >= 2;
            default:           return level >= 3;
        endcase
    endfunction

endpackage

// File: rtl/pgc_domain_fsm.sv
module pgc_domain_fsm
    import pgc_pkg::*;
#(
    parameter int WAKE_LAT = 3,
    parameter bit FORCE_ON = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wake,
    input  logic     idle,
    output pd_ctrl_t ctrl
);
    localparam int CW = $clog2(WAKE_LAT + 1);
    localparam logic [CW-1:0] LOAD = CW'(WAKE_LAT - 1);

    pd_state_e state, nxt_state;
    logic [CW-1:0] cnt, nxt_cnt;

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        case (state)
            PD_OFF: begin
                if (wake) begin
                    nxt_state = PD_WAKING;
                    nxt_cnt   = LOAD;
                end
            end
            PD_WAKING: begin
                if (cnt == CW'(1)) begin
                    nxt_state = PD_ON;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt - CW'(1);
                end
            end
            PD_ON: begin
                if (!FORCE_ON && idle && !wake) nxt_state = PD_OFF;
            end
            default: nxt_state = PD_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FORCE_ON ? PD_ON : PD_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    assign ctrl.pwr_on = (state != PD_OFF);
    assign ctrl.iso_en = (state != PD_ON);

    // R2
    wake_to_power_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PD_OFF && wake) |=> (ctrl.pwr_on && ctrl.iso_en));

    // R3
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PD_WAKING) |-> (cnt != '0 && cnt < CW'(WAKE_LAT)));

    // R4
    sleep_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl.pwr_on) |-> $past(idle && !wake));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.iso_en && wake) |=> (ctrl.pwr_on && !ctrl.iso_en));

    // R7
    pinned_on_chk: assert property (@(posedge clk) disable iff (rst)
        (FORCE_ON == 1'b1) |-> (ctrl.pwr_on && !ctrl.iso_en));

endmodule

// File: rtl/pgc_stall_map.sv
module pgc_stall_map #(
    parameter int NPORT = 5,
    parameter int NBUF  = 20,
    parameter int ND    = 35
) (
    input  logic [ND-1:0]    iso_en,
    output logic [NBUF-1:0]  in_stall,
    output logic [NPORT-1:0] out_stall
);
    assign in_stall = iso_en[NBUF-1:0];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign out_stall[p] = iso_en[NBUF + p]
                            | iso_en[NBUF + NPORT + p]
                            | iso_en[NBUF + 2*NPORT + p];
    end
endmodule

// File: rtl/pgc_router_sleep_ctrl.sv
module pgc_router_sleep_ctrl
    import pgc_pkg::*;
#(
    parameter int NPORT    = 5,
    parameter int NVC      = 4,
    parameter int WAKE_LAT = 3,
    parameter int PG_LEVEL = 3,
    parameter logic [NPORT*NVC-1:0] AON_MASK = 20'h50000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT*NVC+3*NPORT-1:0] dom_wake,
    input  logic [NPORT*NVC+3*NPORT-1:0] dom_idle,
    output logic [NPORT*NVC+3*NPORT-1:0] pwr_on,
    output logic [NPORT*NVC+3*NPORT-1:0] iso_en,
    output logic [NPORT*NVC-1:0]         in_stall,
    output logic [NPORT-1:0]             out_stall
);
    localparam int NBUF = NPORT * NVC;
    localparam int ND   = NBUF + 3 * NPORT;
    localparam logic [ND-1:0] AON_ALL = {{(3*NPORT){1'b0}}, AON_MASK};

    for (genvar d = 0; d < ND; d++) begin : g_dom
        localparam dom_kind_e KIND  = kind_of(d, NBUF, NPORT);
        localparam bit        FORCE = !kind_gated(KIND, PG_LEVEL) || AON_ALL[d];
        pd_ctrl_t ctrl;

        pgc_domain_fsm #(
            .WAKE_LAT (WAKE_LAT),
            .FORCE_ON (FORCE)
        ) u_fsm (
            .clk  (clk),
            .rst  (rst),
            .wake (dom_wake[d]),
            .idle (dom_idle[d]),
            .ctrl (ctrl)
        );

        assign pwr_on[d] = ctrl.pwr_on;
        assign iso_en[d] = ctrl.iso_en;
    end

    pgc_stall_map #(
        .NPORT (NPORT),
        .NBUF  (NBUF),
        .ND    (ND)
    ) u_stall (
        .iso_en    (iso_en),
        .in_stall  (in_stall),
        .out_stall (out_stall)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        // R9
        path_ready_chk: assert property (@(posedge clk) disable iff (rst)
            !out_stall[p] |-> (!iso_en[NBUF+p] && !iso_en[NBUF+NPORT+p]
                               && !iso_en[NBUF+2*NPORT+p]));
    end

endmodule

// File: tb/pgc_router_sleep_ctrl_bench.sv
module pgc_router_sleep_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 35;
    localparam int K_PWR = 0, K_ISO = 1, K_INS = 2, K_OUTS = 3;

    typedef struct {
        int    due;
        bit    inst;
        int    kind;
        int    idx;
        bit    val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ND-1:0] wake_m = '0, idle_m = '0, wake_s = '0, idle_s = '0;
    logic [ND-1:0] pwr_m, iso_m, pwr_s, iso_s;
    logic [19:0] ins_m, ins_s;
    logic [4:0]  outs_m, outs_s;

    int cyc = 0, total = 0, bad = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pgc_router_sleep_ctrl u_pgc_router_sleep_ctrl (
        .clk(clk), .rst(rst), .dom_wake(wake_m), .dom_idle(idle_m),
        .pwr_on(pwr_m), .iso_en(iso_m), .in_stall(ins_m), .out_stall(outs_m));

    pgc_router_sleep_ctrl #(.WAKE_LAT(2), .PG_LEVEL(1)) u_pgc_router_sleep_ctrl_l1 (
        .clk(clk), .rst(rst), .dom_wake(wake_s), .dom_idle(idle_s),
        .pwr_on(pwr_s), .iso_en(iso_s), .in_stall(ins_s), .out_stall(outs_s));

    function automatic bit actual(input bit inst, input int kind, input int idx);
        case (kind)
            K_PWR:   return inst ? pwr_s[idx] : pwr_m[idx];
            K_ISO:   return inst ? iso_s[idx] : iso_m[idx];
            K_INS:   return inst ? ins_s[idx] : ins_m[idx];
            default: return inst ? outs_s[idx] : outs_m[idx];
        endcase
    endfunction

    task automatic expect_at(input bit inst, input int kind, input int idx,
                             input bit val, input int k, input string tag);
        exp_t e;
        e.due = cyc + k; e.inst = inst; e.kind = kind; e.idx = idx;
        e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // monitor: samples one time unit after each active edge
    always @(posedge clk) begin
        exp_t rest[$];
        #1;
        cyc++;
        rest = {};
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].due == cyc) begin
                bit a;
                a = actual(q[i].inst, q[i].kind, q[i].idx);
                total++;
                if (a !== q[i].val) begin
                    bad++;
                    $display("FAIL %s cyc=%0d inst=%0d kind=%0d idx=%0d actual=%0b expected=%0b",
                             q[i].tag, cyc, q[i].inst, q[i].kind, q[i].idx, a, q[i].val);
                end
            end else begin
                rest.push_back(q[i]);
            end
        end
        q = rest;
        if (cyc >= 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state, R7/R8 forced-on domains
        expect_at(0, K_PWR, 0, 0, 1, "R1");
        expect_at(0, K_ISO, 0, 1, 1, "R1");
        expect_at(0, K_PWR, 20, 0, 1, "R1");
        expect_at(0, K_ISO, 16, 0, 1, "R7");
        expect_at(1, K_ISO, 20, 0, 1, "R8");
        expect_at(1, K_ISO, 0, 1, 1, "R1");
        step(); step();

        // R2 latency on buffer 0, R9 buffer stall, R10 neighbour untouched
        wake_m[0] = 1'b1;
        expect_at(0, K_PWR, 0, 1, 1, "R2");
        expect_at(0, K_ISO, 0, 1, 1, "R2");
        expect_at(0, K_ISO, 0, 1, 2, "R2");
        expect_at(0, K_ISO, 0, 0, 3, "R2");
        expect_at(0, K_INS, 0, 0, 3, "R9");
        expect_at(0, K_INS, 1, 1, 3, "R10");
        step(); wake_m[0] = 1'b0;
        repeat (4) step();

        // R3 repeated wake does not restart
        wake_m[1] = 1'b1;
        expect_at(0, K_ISO, 1, 1, 2, "R3");
        expect_at(0, K_ISO, 1, 0, 3, "R3");
        step(); step(); wake_m[1] = 1'b0;
        repeat (4) step();

        // R6 idle ignored while waking, then R4 sleep
        wake_m[2] = 1'b1;
        expect_at(0, K_PWR, 2, 1, 2, "R6");
        expect_at(0, K_ISO, 2, 0, 3, "R6");
        expect_at(0, K_PWR, 2, 0, 4, "R4");
        expect_at(0, K_ISO, 2, 1, 4, "R4");
        step(); wake_m[2] = 1'b0; idle_m[2] = 1'b1;
        repeat (4) step(); idle_m[2] = 1'b0;
        step();

        // R5 wake wins over idle, then R4 sleep when wake drops
        wake_m[0] = 1'b1; idle_m[0] = 1'b1;
        expect_at(0, K_PWR, 0, 1, 1, "R5");
        expect_at(0, K_ISO, 0, 0, 1, "R5");
        step(); wake_m[0] = 1'b0;
        expect_at(0, K_PWR, 0, 0, 1, "R4");
        expect_at(0, K_ISO, 0, 1, 1, "R4");
        step(); idle_m[0] = 1'b0;
        step();

        // R7 always-on buffers ignore idle
        idle_m[16] = 1'b1; idle_m[18] = 1'b1;
        expect_at(0, K_PWR, 16, 1, 2, "R7");
        expect_at(0, K_ISO, 18, 0, 2, "R7");
        step(); step(); idle_m[16] = 1'b0; idle_m[18] = 1'b0;
        step();

        // R9 output path stall needs all three domains of port 1
        wake_m[21] = 1'b1; wake_m[26] = 1'b1;
        expect_at(0, K_OUTS, 1, 1, 3, "R9");
        expect_at(0, K_OUTS, 1, 0, 4, "R9");
        expect_at(0, K_OUTS, 0, 1, 4, "R10");
        step(); wake_m[21] = 1'b0; wake_m[26] = 1'b0; wake_m[31] = 1'b1;
        step(); wake_m[31] = 1'b0;
        repeat (4) step();

        // R8 level-1 instance: buffers gated with 2-cycle wake, others forced on
        wake_s[3] = 1'b1; idle_s[20] = 1'b1; idle_s[30] = 1'b1;
        expect_at(1, K_ISO, 3, 1, 1, "R8");
        expect_at(1, K_ISO, 3, 0, 2, "R2");
        expect_at(1, K_PWR, 20, 1, 2, "R8");
        expect_at(1, K_ISO, 30, 0, 2, "R8");
        expect_at(1, K_OUTS, 0, 0, 2, "R8");
        step(); wake_s[3] = 1'b0;
        step(); step(); idle_s[20] = 1'b0; idle_s[30] = 1'b0;
        repeat (3) step();

        if (q.size() != 0) begin
            bad += q.size();
            total += q.size();
            $display("FAIL unchecked items actual=%0d expected=0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule